// File: doc/BRIEF.md
# Response Word to Network Flit Serializer

The block sits between the response side of a target on a word-oriented system bus and a packet network whose flits are 33 bits wide. Each cycle it can accept one response word through a valid/ready handshake. A word carries 32 bits of read data, a source identifier, a 4-bit transaction tag, a 4-bit packet tag, a one-bit error flag, a two-bit command kind and an end-of-packet marker. On the other side it emits flits through a second valid/ready handshake. The top bit of each flit marks the last flit of a network packet.

For every response the block picks the shortest encoding. Some responses need no data on the network: a one-word response to a write, and a one-word response to a read, store-conditional or compare-and-swap whose data is zero. These become a single header flit. Every other response becomes a header flit followed by one flit per input word. The choice depends on the first word's end marker and data, so the block always captures the first word before it emits anything. It then holds off its input until the header has gone out.

Top module: `rsp_flit_serializer`

## Requirements
- R1: A header flit carries the error flag in bit 0, the packet tag in bits 4:1, the transaction tag in bits 8:5 and the source identifier in bits 22:9. Bits 31:23 are zero, and bit 32 is the end-of-packet flag.
- R2: A one-word response with command kind write (code 1) yields exactly one flit: the header with bit 32 set, whatever the data value.
- R3: A one-word response with command kind read (code 0) and data zero yields exactly one flit: the header with bit 32 set.
- R4: A one-word response with command kind store-conditional (code 2) or compare-and-swap (code 3) and data zero yields exactly one flit: the header with bit 32 set.
- R5: A one-word response of kind read, store-conditional or compare-and-swap with nonzero data yields two flits. The first is the header with bit 32 clear. The second holds the data in bits 31:0 with bit 32 set.
- R6: A response of N > 1 words yields N+1 flits: the header, then the data words in arrival order. Bit 32 is set only on the flit from the last input word, so exactly one flit per packet carries it.
- R7: After reset, and whenever no response is in progress, out_valid_o is low and in_ready_o is high.
- R8: While out_valid_o is high and out_ready_i is low, the flit and out_valid_o stay unchanged on the next cycle.
- R9: In the cycle after a response's first word is accepted, in_ready_o is low and out_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Response word valid |
| in_ready_o | output | 1 | Response word accepted when high with valid |
| in_eop_i | input | 1 | Last word of the response |
| in_cmd_i | input | 2 | Command kind: 0 read, 1 write, 2 store-conditional, 3 compare-and-swap |
| in_err_i | input | 1 | Error flag |
| in_srcid_i | input | SRCID_W (14) | Source identifier |
| in_trdid_i | input | TRD_W (4) | Transaction tag |
| in_pktid_i | input | PKT_W (4) | Packet tag |
| in_data_i | input | DATA_W (32) | Read data word |
| out_valid_o | output | 1 | Flit valid |
| out_ready_i | input | 1 | Network accepts flit |
| out_flit_o | output | DATA_W+1 (33) | Flit, bit 32 is end-of-packet |

## Verification
The bench builds the block with its default widths: 32-bit data, a 14-bit source identifier and 4-bit tags. Random identifiers and flags therefore cover every header bit position, including the boundary between the source field and the zero padding. Mixing single-word responses of all four command kinds with zero and nonzero data reaches every branch of the length decision. Random output backpressure stalls the header, the held first word and pass-through words. This exposes reordering or loss at each state change.

// File: rtl/rsp_ser_pkg.sv
package rsp_ser_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_SC    = 2'd2,
    CMD_CAS   = 2'd3
  } rsp_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_HELD = 2'd2,
    ST_PASS = 2'd3
  } ser_state_e;
endpackage

// File: rtl/rsp_len_classify.sv
module rsp_len_classify #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        cmd_i,
  input  logic              eop_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              compact_o
);
  import rsp_ser_pkg::*;

  logic no_payload;

  always_comb begin
    unique case (rsp_cmd_e'(cmd_i))
      CMD_WRITE: no_payload = 1'b1;
      default:   no_payload = (data_i == '0);
    endcase
    compact_o = eop_i && no_payload;
  end
endmodule

// File: rtl/rsp_hdr_pack.sv
module rsp_hdr_pack #(
  parameter int DATA_W  = 32,
  parameter int SRCID_W = 14,
  parameter int TRD_W   = 4,
  parameter int PKT_W   = 4
) (
  input  logic               err_i,
  input  logic [PKT_W-1:0]   pktid_i,
  input  logic [TRD_W-1:0]   trdid_i,
  input  logic [SRCID_W-1:0] srcid_i,
  output logic [DATA_W-1:0]  hdr_o
);
  localparam int USED_W = 1 + PKT_W + TRD_W + SRCID_W;
  localparam int PAD_W  = DATA_W - USED_W;

  generate
    if (PAD_W > 0) begin : g_pad
      assign hdr_o = {{PAD_W{1'b0}}, srcid_i, trdid_i, pktid_i, err_i};
    end else begin : g_nopad
      assign hdr_o = {srcid_i, trdid_i, pktid_i, err_i};
    end
  endgenerate
endmodule

// File: rtl/rsp_flit_serializer.sv
module rsp_flit_serializer #(
  parameter int DATA_W  = 32,
  parameter int SRCID_W = 14,
  parameter int TRD_W   = 4,
  parameter int PKT_W   = 4,
  localparam int FLIT_W = DATA_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic               in_eop_i,
  input  logic [1:0]         in_cmd_i,
  input  logic               in_err_i,
  input  logic [SRCID_W-1:0] in_srcid_i,
  input  logic [TRD_W-1:0]   in_trdid_i,
  input  logic [PKT_W-1:0]   in_pktid_i,
  input  logic [DATA_W-1:0]  in_data_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [FLIT_W-1:0]  out_flit_o
);
  import rsp_ser_pkg::*;

  ser_state_e         st_q, st_d;
  logic               h_eop_q, h_err_q;
  logic [1:0]         h_cmd_q;
  logic [SRCID_W-1:0] h_srcid_q;
  logic [TRD_W-1:0]   h_trdid_q;
  logic [PKT_W-1:0]   h_pktid_q;
  logic [DATA_W-1:0]  h_data_q;
  logic               load;
  logic               compact;
  logic [DATA_W-1:0]  hdr;

  rsp_len_classify #(.DATA_W(DATA_W)) i_classify (
    .cmd_i     (h_cmd_q),
    .eop_i     (h_eop_q),
    .data_i    (h_data_q),
    .compact_o (compact)
  );

  rsp_hdr_pack #(
    .DATA_W (DATA_W), .SRCID_W(SRCID_W), .TRD_W(TRD_W), .PKT_W(PKT_W)
  ) i_hdr (
    .err_i   (h_err_q),
    .pktid_i (h_pktid_q),
    .trdid_i (h_trdid_q),
    .srcid_i (h_srcid_q),
    .hdr_o   (hdr)
  );

  always_comb begin
    st_d        = st_q;
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_flit_o  = '0;
    load        = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        in_ready_o = 1'b1;
        if (in_valid_i) begin
          load = 1'b1;
          st_d = ST_HDR;
        end
      end
      ST_HDR: begin
        out_valid_o = 1'b1;
        out_flit_o  = {compact, hdr};
        if (out_ready_i) st_d = compact ? ST_IDLE : ST_HELD;
      end
      ST_HELD: begin
        out_valid_o = 1'b1;
        out_flit_o  = {h_eop_q, h_data_q};
        if (out_ready_i) st_d = h_eop_q ? ST_IDLE : ST_PASS;
      end
      ST_PASS: begin
        // remaining words stream straight through
        out_valid_o = in_valid_i;
        in_ready_o  = out_ready_i;
        out_flit_o  = {in_eop_i, in_data_i};
        if (in_valid_i && out_ready_i && in_eop_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      h_eop_q   <= 1'b0;
      h_err_q   <= 1'b0;
      h_cmd_q   <= 2'd0;
      h_srcid_q <= '0;
      h_trdid_q <= '0;
      h_pktid_q <= '0;
      h_data_q  <= '0;
    end else begin
      st_q <= st_d;
      if (load) begin
        h_eop_q   <= in_eop_i;
        h_err_q   <= in_err_i;
        h_cmd_q   <= in_cmd_i;
        h_srcid_q <= in_srcid_i;
        h_trdid_q <= in_trdid_i;
        h_pktid_q <= in_pktid_i;
        h_data_q  <= in_data_i;
      end
    end
  end
endmodule

// File: rtl/rsp_ser_checker.sv
module rsp_ser_checker #(
  parameter int FLIT_W = 33
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              in_eop_i,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [FLIT_W-1:0] out_flit_o
);
  logic in_hs, out_hs, out_last;
  logic busy_q, eop_seen_q;

  assign in_hs    = in_valid_i && in_ready_o;
  assign out_hs   = out_valid_o && out_ready_i;
  assign out_last = out_hs && out_flit_o[FLIT_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      eop_seen_q <= 1'b0;
    end else begin
      if (out_last)   busy_q <= 1'b0;
      else if (in_hs) busy_q <= 1'b1;
      if (out_last)               eop_seen_q <= 1'b0;
      else if (in_hs && in_eop_i) eop_seen_q <= 1'b1;
    end
  end

  assert_idle_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (!out_valid_o && in_ready_o));

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_flit_o)));

  assert_first_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_hs && !busy_q) |=> (!in_ready_o && out_valid_o));

  assert_eop_follows_input_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last |-> (eop_seen_q || (in_hs && in_eop_i)));
endmodule

bind rsp_flit_serializer rsp_ser_checker #(.FLIT_W(FLIT_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .in_eop_i    (in_eop_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_flit_o  (out_flit_o)
);

// File: tb/test_rsp_flit_serializer.sv
module test_rsp_flit_serializer;
  localparam int DATA_W  = 32;
  localparam int SRCID_W = 14;
  localparam int TRD_W   = 4;
  localparam int PKT_W   = 4;
  localparam int FLIT_W  = DATA_W + 1;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic               in_eop = 1'b0;
  logic [1:0]         in_cmd = 2'd0;
  logic               in_err = 1'b0;
  logic [SRCID_W-1:0] in_srcid = '0;
  logic [TRD_W-1:0]   in_trdid = '0;
  logic [PKT_W-1:0]   in_pktid = '0;
  logic [DATA_W-1:0]  in_data = '0;
  logic               out_valid;
  logic               out_ready = 1'b1;
  logic [FLIT_W-1:0]  out_flit;

  int checks = 0;
  int fails = 0;
  bit bp_on = 1'b0;
  bit done = 1'b0;

  logic [FLIT_W-1:0] exp_q[$];
  string             tag_q[$];
  int                len_q[$];

  always #10 clk = ~clk;

  rsp_flit_serializer #(
    .DATA_W(DATA_W), .SRCID_W(SRCID_W), .TRD_W(TRD_W), .PKT_W(PKT_W)
  ) i_rsp_flit_serializer (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_eop_i(in_eop),
    .in_cmd_i(in_cmd), .in_err_i(in_err), .in_srcid_i(in_srcid),
    .in_trdid_i(in_trdid), .in_pktid_i(in_pktid), .in_data_i(in_data),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_flit_o(out_flit)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] mk_hdr(logic [SRCID_W-1:0] s, logic [TRD_W-1:0] t,
                                               logic [PKT_W-1:0] p, logic e);
    return {9'd0, s, t, p, e};  // R1 layout
  endfunction

  function automatic bit is_compact(int n, logic [1:0] cmd, logic [DATA_W-1:0] d0);
    if (n != 1) return 1'b0;
    if (cmd == 2'd1) return 1'b1;
    return d0 == '0;
  endfunction

  always @(negedge clk) out_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;

  // output monitor, samples mid low phase
  bit                stall_prev = 1'b0;
  logic [FLIT_W-1:0] stall_flit;
  int                pkt_cnt = 0;
  always @(negedge clk) begin
    #5;
    if (rst_n) begin
      if (stall_prev)
        chk(out_valid && out_flit == stall_flit, "R8 hold under stall", 64'(out_flit), 64'(stall_flit));
      stall_prev = out_valid && !out_ready;
      stall_flit = out_flit;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected flit", 64'(out_flit), 64'd0);
        end else begin
          logic [FLIT_W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(out_flit == e, t, 64'(out_flit), 64'(e));
        end
        pkt_cnt++;
        if (out_flit[FLIT_W-1]) begin
          int l;
          l = (len_q.size() != 0) ? len_q.pop_front() : -1;
          chk(pkt_cnt == l, "R6 flit count per packet", 64'(pkt_cnt), 64'(l));
          pkt_cnt = 0;
        end
      end
    end
  end

  task automatic send_pkt(input int n, input logic [1:0] cmd, input bit zero);
    logic [DATA_W-1:0]  d[$];
    logic [SRCID_W-1:0] s;
    logic [TRD_W-1:0]   t;
    logic [PKT_W-1:0]   p;
    logic               e;
    string              tag;
    s = SRCID_W'($urandom);
    t = TRD_W'($urandom);
    p = PKT_W'($urandom);
    e = 1'($urandom);
    for (int i = 0; i < n; i++) begin
      logic [DATA_W-1:0] w;
      w = $urandom;
      if (n == 1 && zero) w = '0;
      if (n == 1 && !zero && w == '0) w = 32'd1;
      d.push_back(w);
    end
    if (is_compact(n, cmd, d[0])) begin
      tag = (cmd == 2'd1) ? "R2 write single" : (cmd == 2'd0) ? "R3 read zero" : "R4 sc/cas zero";
      exp_q.push_back({1'b1, mk_hdr(s, t, p, e)});
      tag_q.push_back({tag, " R1 header"});
      len_q.push_back(1);
    end else begin
      tag = (n == 1) ? "R5 single nonzero" : "R6 multi word";
      exp_q.push_back({1'b0, mk_hdr(s, t, p, e)});
      tag_q.push_back({tag, " R1 header"});
      for (int i = 0; i < n; i++) begin
        exp_q.push_back({(i == n - 1), d[i]});
        tag_q.push_back({tag, " data"});
      end
      len_q.push_back(n + 1);
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_eop   = (i == n - 1);
      in_cmd   = cmd;
      in_err   = e;
      in_srcid = s;
      in_trdid = t;
      in_pktid = p;
      in_data  = d[i];
      #5;
      if (i == 1) chk(!in_ready && out_valid, "R9 stall after first word", 64'({in_ready, out_valid}), 64'b01);
      while (!in_ready) begin
        @(negedge clk);
        #5;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = $urandom;
    if (n == 1) begin
      #5;
      chk(!in_ready && out_valid, "R9 stall after single word", 64'({in_ready, out_valid}), 64'b01);
    end
  endtask

  task automatic drain();
    int g = 0;
    while ((exp_q.size() != 0 || out_valid) && g < 2000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
    #5;
    chk(!out_valid && in_ready, "R7 idle after packet", 64'({out_valid, in_ready}), 64'b01);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_0a17));
    #5;
    chk(!out_valid, "R7 out_valid in reset", 64'(out_valid), 64'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #5;
    chk(!out_valid && in_ready, "R7 after reset", 64'({out_valid, in_ready}), 64'b01);

    // directed corners, no backpressure
    send_pkt(1, 2'd1, 1'b0); drain();  // write with nonzero data
    send_pkt(1, 2'd1, 1'b1); drain();
    send_pkt(1, 2'd0, 1'b1); drain();
    send_pkt(1, 2'd2, 1'b1); drain();
    send_pkt(1, 2'd3, 1'b1); drain();
    send_pkt(1, 2'd0, 1'b0); drain();
    send_pkt(1, 2'd3, 1'b0); drain();
    send_pkt(3, 2'd1, 1'b0); drain();
    send_pkt(8, 2'd0, 1'b0); drain();

    // random mix with backpressure
    bp_on = 1'b1;
    for (int k = 0; k < 300; k++) begin
      int n;
      n = ($urandom % 3 == 0) ? 2 + int'($urandom % 7) : 1;
      send_pkt(n, 2'($urandom), 1'($urandom));
      if ($urandom % 5 == 0) drain();
    end
    drain();
    bp_on = 1'b0;
    send_pkt(2, 2'd2, 1'b0);
    send_pkt(1, 2'd0, 1'b1);
    drain();
    chk(exp_q.size() == 0, "R6 all flits seen", 64'(exp_q.size()), 64'd0);
    summary();
  end
endmodule